// File: doc/BRIEF.md
# Two-Wire Serial Register Target

This block is a target device for an I2C-style two-wire bus. It watches an open-drain clock line and data line with a faster system clock, finds the framing conditions, and serves a small file of 8-bit registers. A controller addresses it with a 7-bit target address and a direction bit. On a write, the first byte after the address selects the register. Its top bit chooses between block access, where the register pointer steps after every data byte, and single access, where every byte goes to the same register. The data bytes that follow are stored. On a read, the target returns register contents starting at the current pointer.

The pointer survives a repeated START. The usual way to read is therefore a write of the register byte, a repeated START, and then a read. The target drives the data line only by pulling it low, through an output enable. The data line is left released whenever the target has no acknowledge or zero bit to place on it.

Top module: `i2cRegTarget`

## Requirements
- R1: A falling data line while the clock line is high (START or repeated START) starts a new address phase from any state, with the bit count cleared.
- R2: A rising data line while the clock line is high (STOP) returns the target to idle; the target never pulls the data line low while idle, including straight after reset.
- R3: Address bits arrive MSB first and are followed by a direction bit (0 = controller writes, 1 = controller reads). On a match with `TGT_ADDR` the target pulls the data line low for the whole ninth clock pulse.
- R4: On an address mismatch the target gives no acknowledge (the line reads 1) and changes no register until the next START or STOP.
- R5: The register byte after a write address is acknowledged. Bit 7 is the block flag (1 = block, 0 = single) and the low log2(`NUM_REGS`) bits set the pointer.
- R6: Each data byte written is acknowledged and stored in the register at the pointer.
- R7: In block mode the pointer advances by one after each byte written or loaded for sending, and wraps from `NUM_REGS`-1 to 0.
- R8: In single mode every further byte, written or read, accesses the same register.
- R9: Read data leaves MSB first. The target starts pulling the data line low only while the clock line is low.
- R10: A NACK (data line high) from the controller after a read byte makes the target release the data line until the next START or STOP.
- R11: The pointer and block flag keep their values across a repeated START, so a read right after a register-select write starts at the selected register.
- R12: The target puts no limit on the number of data bytes in one transfer. Every byte of a long block write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOutEn | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The lines pass through two synchroniser flops and an edge register, so the acknowledge or data bit the target places on the line appears three system cycles after the bus clock falls. A register write takes effect at the clock fall that ends the eighth data bit. The bench holds each bus clock phase for eight system cycles and samples the data line in the middle of the clock-high phase, well after every response is due. Each expected acknowledge or byte is queued before its bus clocks are sent. The monitor compares it with the value captured at that sample point.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic setPtr;
    logic writeReg;
    logic incPtr;
  } dpStrobe_t;
endpackage

// File: rtl/i2cTgtSync.sv
module i2cTgtSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/i2cTgtCtrl.sv
module i2cTgtCtrl
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  input  logic              blockMode,
  output dpStrobe_t         strb,
  output logic              sdaOutEn,
  output logic              stateIdle,
  output logic              stateIgnore,
  output logic              stateAddr
);
  localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

  tgtState_e state, stateNxt;
  logic [3:0] bitCnt, bitCntNxt;
  logic ackDrive, ackDriveNxt;
  logic ctlAck, ctlAckNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      ctlAck   <= 1'b1;
    end else begin
      state    <= stateNxt;
      bitCnt   <= bitCntNxt;
      ackDrive <= ackDriveNxt;
      ctlAck   <= ctlAckNxt;
    end
  end

  always_comb begin
    stateNxt    = state;
    bitCntNxt   = bitCnt;
    ackDriveNxt = ackDrive;
    ctlAckNxt   = ctlAck;
    strb        = '0;
    if (stopDet) begin
      stateNxt    = ST_IDLE;
      ackDriveNxt = 1'b0;
    end else if (startDet) begin
      stateNxt    = ST_ADDR;
      bitCntNxt   = '0;
      ackDriveNxt = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_REG, ST_WDATA: begin
          if (sclRise && bitCnt != BITS_PER_BYTE) begin
            strb.shiftIn = 1'b1;
            bitCntNxt    = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == BITS_PER_BYTE) begin
            if (state == ST_ADDR) begin
              if (rxByte[BYTE_W-1:1] == TGT_ADDR) begin
                ackDriveNxt = 1'b1;
                stateNxt    = ST_ADDR_ACK;
              end else begin
                stateNxt = ST_IGNORE;
              end
            end else if (state == ST_REG) begin
              strb.setPtr = 1'b1;
              ackDriveNxt = 1'b1;
              stateNxt    = ST_REG_ACK;
            end else begin
              strb.writeReg = 1'b1;
              strb.incPtr   = blockMode;
              ackDriveNxt   = 1'b1;
              stateNxt      = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackDriveNxt = 1'b0;
            bitCntNxt   = '0;
            if (rxByte[0]) begin
              strb.loadTx = 1'b1;
              strb.incPtr = blockMode;
              stateNxt    = ST_RDATA;
            end else begin
              stateNxt = ST_REG;
            end
          end
        end
        ST_REG_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            ackDriveNxt = 1'b0;
            bitCntNxt   = '0;
            stateNxt    = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == BITS_PER_BYTE - 4'd1) begin
              bitCntNxt = '0;
              stateNxt  = ST_RACK;
            end else begin
              strb.shiftTx = 1'b1;
              bitCntNxt    = bitCnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            ctlAckNxt = sdaS;
          end else if (sclFall) begin
            if (!ctlAck) begin
              strb.loadTx = 1'b1;
              strb.incPtr = blockMode;
              bitCntNxt   = '0;
              stateNxt    = ST_RDATA;
            end else begin
              stateNxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOutEn    = ackDrive | ((state == ST_RDATA) & ~txBit);
  assign stateIdle   = (state == ST_IDLE);
  assign stateIgnore = (state == ST_IGNORE);
  assign stateAddr   = (state == ST_ADDR);
endmodule

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  dpStrobe_t         strb,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic              blockMode,
  output logic [PTR_W-1:0]  ptr
);
  localparam int BLOCK_BIT = BYTE_W - 1;

  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] regFile [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte    <= '0;
      txShift   <= '1;
      blockMode <= 1'b0;
      ptr       <= '0;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (strb.loadTx) txShift <= regFile[ptr];
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (strb.setPtr) begin
        ptr       <= rxByte[PTR_W-1:0];
        blockMode <= rxByte[BLOCK_BIT];
      end else if (strb.incPtr) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= '0;
      else if (strb.writeReg && ptr == PTR_W'(g)) regFile[g] <= rxByte;
    end
  end

  assign txBit = txShift[BYTE_W-1];
endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h2A,
  parameter int NUM_REGS         = 16,
  parameter int SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOutEn
);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic sdaS, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic txBit, blockMode;
  logic [PTR_W-1:0] ptr;
  logic stateIdle, stateIgnore, stateAddr, incPtr;
  dpStrobe_t strb;

  i2cTgtSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  i2cTgtCtrl #(.TGT_ADDR(TGT_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxByte(rxByte), .txBit(txBit),
    .blockMode(blockMode), .strb(strb), .sdaOutEn(sdaOutEn),
    .stateIdle(stateIdle), .stateIgnore(stateIgnore), .stateAddr(stateAddr)
  );

  i2cTgtDatapath #(.NUM_REGS(NUM_REGS)) uDp (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .strb(strb), .rxByte(rxByte),
    .txBit(txBit), .blockMode(blockMode), .ptr(ptr)
  );

  assign incPtr = strb.incPtr;
endmodule

module i2cTgtChecker #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaOutEn,
  input logic             startDet,
  input logic             stateIdle,
  input logic             stateIgnore,
  input logic             stateAddr,
  input logic             incPtr,
  input logic [PTR_W-1:0] ptr
);
  // R1
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> stateAddr);
  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateIdle |-> !sdaOutEn);
  // R4 R10
  ignore_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateIgnore |-> !sdaOutEn);
  // R9
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOutEn) |-> !sclIn);
  // R7
  ptr_step_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    incPtr |=> ptr == PTR_W'($past(ptr) + 1'b1));
endmodule

bind i2cRegTarget i2cTgtChecker #(.PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOutEn(sdaOutEn),
  .startDet(startDet), .stateIdle(stateIdle), .stateIgnore(stateIgnore),
  .stateAddr(stateAddr), .incPtr(incPtr), .ptr(ptr)
);

// File: tb/tb_i2cRegTarget.sv
module tb_i2cRegTarget;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic tbLow = 1'b0;
  logic sdaOutEn;
  wire  sdaLine = ~(tbLow | sdaOutEn);

  int checks = 0;
  int errors = 0;
  int expQ[$];
  string tagQ[$];
  int obsQ[$];

  always #4 clk = ~clk;

  i2cRegTarget #(.TGT_ADDR(ADDR), .NUM_REGS(16)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .sdaOutEn(sdaOutEn)
  );

  task automatic expectItem(input string tag, input int v);
    tagQ.push_back(tag);
    expQ.push_back(v);
  endtask

  // monitor: compares observed results against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0) begin
        int a, e;
        string t;
        a = obsQ.pop_front();
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL unexpected result: actual=%0h expected=none", a);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (a != e) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", t, a, e);
          end
        end
      end
    end
  end

  task automatic halfWait();
    repeat (H) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    tbLow = ~b;
    halfWait();
    sclLine = 1'b1;
    halfWait();
    sclLine = 1'b0;
  endtask

  task automatic readBit(output logic b);
    tbLow = 1'b0;
    halfWait();
    sclLine = 1'b1;
    repeat (H / 2) @(negedge clk);
    b = sdaLine;
    repeat (H / 2) @(negedge clk);
    sclLine = 1'b0;
  endtask

  task automatic busStart();
    tbLow = 1'b0;
    halfWait();
    sclLine = 1'b1;
    halfWait();
    tbLow = 1'b1;
    halfWait();
    sclLine = 1'b0;
  endtask

  task automatic busStop();
    tbLow = 1'b1;
    halfWait();
    sclLine = 1'b1;
    halfWait();
    tbLow = 1'b0;
    halfWait();
  endtask

  task automatic sendByte(input logic [7:0] v, input logic expAck, input string tag);
    logic a;
    expectItem(tag, int'(expAck));
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    readBit(a);
    obsQ.push_back(int'(a));
  endtask

  task automatic readByte(input logic [7:0] expV, input logic ackBit, input string tag);
    logic [7:0] got;
    logic b;
    expectItem(tag, int'(expV));
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      got[i] = b;
    end
    obsQ.push_back(int'(got));
    sendBit(ackBit);
  endtask

  task automatic checkIdle(input string tag);
    expectItem(tag, 0);
    obsQ.push_back(int'(sdaOutEn));
  endtask

  task automatic writeRegs(input logic [7:0] regByte, input logic [7:0] d0,
                           input logic [7:0] d1, input int n);
    busStart();
    sendByte({ADDR, 1'b0}, 1'b0, "R3 address ack on write");
    sendByte(regByte, 1'b0, "R5 register byte ack");
    if (n > 0) sendByte(d0, 1'b0, "R6 data ack");
    if (n > 1) sendByte(d1, 1'b0, "R6 data ack");
    busStop();
  endtask

  task automatic selectForRead(input logic [7:0] regByte);
    busStart();
    sendByte({ADDR, 1'b0}, 1'b0, "R3 address ack on write");
    sendByte(regByte, 1'b0, "R5 register byte ack");
    busStart();
    sendByte({ADDR, 1'b1}, 1'b0, "R1 R3 address ack after repeated START");
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    checkIdle("R2 reset state releases SDA");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkIdle("R2 idle after reset");

    // single write then read back through repeated START
    writeRegs(8'h03, 8'hA5, 8'h00, 1);
    halfWait();
    checkIdle("R2 released after STOP");
    selectForRead(8'h03);
    readByte(8'hA5, 1'b1, "R9 R11 read of register 3");
    // after NACK the target must leave the line released
    readByte(8'hFF, 1'b1, "R10 line released after NACK");
    busStop();

    // single mode: two bytes land in one register
    writeRegs(8'h05, 8'h11, 8'h22, 2);
    selectForRead(8'h05);
    readByte(8'h22, 1'b0, "R8 single mode keeps last byte");
    readByte(8'h22, 1'b1, "R8 single mode read repeats register");
    busStop();
    selectForRead(8'h06);
    readByte(8'h00, 1'b1, "R8 neighbour register untouched");
    busStop();

    // block mode write and read
    busStart();
    sendByte({ADDR, 1'b0}, 1'b0, "R3 address ack");
    sendByte(8'h8A, 1'b0, "R5 block register byte ack");
    sendByte(8'h10, 1'b0, "R7 block data ack");
    sendByte(8'h20, 1'b0, "R7 block data ack");
    sendByte(8'h30, 1'b0, "R7 block data ack");
    busStop();
    selectForRead(8'h8A);
    readByte(8'h10, 1'b0, "R7 block read reg 10");
    readByte(8'h20, 1'b0, "R7 block read reg 11");
    readByte(8'h30, 1'b1, "R7 block read reg 12");
    busStop();

    // wrap from last register to 0
    writeRegs(8'h8F, 8'hE1, 8'hE2, 2);
    selectForRead(8'h8F);
    readByte(8'hE1, 1'b0, "R7 wrap read reg 15");
    readByte(8'hE2, 1'b1, "R7 wrap read reg 0");
    busStop();

    // wrong address: no ack, nothing written
    busStart();
    sendByte({ADDR ^ 7'h01, 1'b0}, 1'b1, "R4 no ack on mismatch");
    sendByte(8'h03, 1'b1, "R4 register byte ignored");
    sendByte(8'h5A, 1'b1, "R4 data byte ignored");
    busStop();
    selectForRead(8'h03);
    readByte(8'hA5, 1'b1, "R4 register 3 unchanged");
    busStop();

    // long block transfer: 20 bytes, all acknowledged
    busStart();
    sendByte({ADDR, 1'b0}, 1'b0, "R3 address ack");
    sendByte(8'h80, 1'b0, "R5 block register byte ack");
    for (int i = 0; i < 20; i++) sendByte(8'(i * 3 + 1), 1'b0, "R12 long transfer ack");
    busStop();
    selectForRead(8'h80);
    for (int k = 0; k < 17; k++) begin
      int r;
      r = k % 16;
      readByte(8'((r < 4) ? (r + 16) * 3 + 1 : r * 3 + 1), (k == 16) ? 1'b1 : 1'b0,
               "R12 long transfer readback");
    end
    busStop();
    halfWait();
    checkIdle("R2 idle at end");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL pending expectations: actual=%0d expected=0", expQ.size());
    end
    report();
  end
endmodule